// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns the two phase signals of an incremental shaft encoder into count pulses and a direction. It keeps a 32-bit position register, a 16-bit position-difference register and a 16-bit revolution register. It can also bypass the quadrature decoding. In that mode each rising edge of phase A is one count, and phase B sets the direction.

The position can wrap between two programmable limits. The revolution register is driven either by the index input or by those wraps. A selected edge of index or home, or a software pulse, loads a programmable start value. A rising edge of the trigger input can clear all three registers.

Six sticky flags record events, and the block drives an interrupt output from them. The flags cover a compare hit, a wrap upward, a wrap downward, an index edge, a home edge, and an illegal change of both phases at once. Configuration arrives on plain input pins that a register file elsewhere drives.

Top module: `qdec_position`

## Requirements
- R1: After reset, position, pos_diff, revolution, dir_up, flags, match_pulse and irq are all zero.
- R2: phase_a, phase_b, index_in, home_in and trigger_in each pass through two synchronizing flops and one edge register. An input change therefore reaches the counters at the third rising clock edge after it is applied.
- R3: In quadrature mode (cfg_count_mode=0), the code {A,B} moving 00→10→11→01→00 counts +1 per step, and the opposite order counts −1. When cfg_reverse=1, both directions are inverted.
- R4: In phase-count mode (cfg_count_mode=1), only a rising edge of synchronized A counts. The count is +1 when B equals cfg_reverse and −1 otherwise.
- R5: dir_up becomes 1 after an applied up count and 0 after an applied down count. It holds its value otherwise.
- R6: Wrap rules:
  - Modulo mode (cfg_modulo_en=1): an up count at upper_lim loads lower_lim and sets flag bit 1; a down count at lower_lim loads upper_lim and sets flag bit 2.
  - Without modulo mode: the position wraps at the 32-bit limits and sets the same flags.
- R7: Revolution updates depend on cfg_rev_src:
  - cfg_rev_src=0: each selected index edge adds +1 when dir_up is 1 and −1 when dir_up is 0. The value of dir_up used is the one held before that edge.
  - cfg_rev_src=1: a wrap upward adds +1 and a wrap downward adds −1.
- R8: Any of these loads init_value into position: sw_init; the selected index edge when cfg_index_init_en=1; the selected home edge when cfg_home_init_en=1. The falling edge is selected when cfg_index_fall or cfg_home_fall is 1, and the rising edge otherwise. A load overrides a count in the same cycle, and an unselected edge does nothing.
- R9: A rising trigger edge with cfg_trig_clear_en=1 clears position, pos_diff and revolution. It takes priority over every other update.
- R10: In quadrature mode, a change of both phases in the same sample sets flag bit 5 and produces no count.
- R11: Behaviour of match_pulse depends on cfg_match_on_read:
  - cfg_match_on_read=0: match_pulse is high for one cycle after any edge that writes position with a value equal to compare_val. The same edge sets flag bit 0.
  - cfg_match_on_read=1: match_pulse is high in the cycle after rd_strobe.
- R12: Flag bits: 0 compare, 1 wrap up, 2 wrap down, 3 index edge, 4 home edge, 5 both-phase change.
  - Each flag is sticky and is cleared by a 1 in the matching flag_clr bit.
  - A new event takes priority over a clear in the same cycle.
  - irq is the OR of flags AND irq_en.
- R13: pos_diff moves by ±1 with each applied count. rd_strobe clears it, and the clear takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Once-per-turn index, asynchronous |
| home_in | input | 1 | Home sensor, asynchronous |
| trigger_in | input | 1 | Clear trigger, asynchronous |
| cfg_count_mode | input | 1 | 0 quadrature, 1 phase-count |
| cfg_reverse | input | 1 | Invert count direction |
| cfg_modulo_en | input | 1 | Wrap between lower_lim and upper_lim |
| cfg_rev_src | input | 1 | 0 index edges, 1 wraps drive revolution |
| cfg_index_init_en | input | 1 | Index edge loads init_value |
| cfg_index_fall | input | 1 | Use falling index edge |
| cfg_home_init_en | input | 1 | Home edge loads init_value |
| cfg_home_fall | input | 1 | Use falling home edge |
| cfg_trig_clear_en | input | 1 | Trigger edge clears counters |
| cfg_match_on_read | input | 1 | match_pulse follows rd_strobe |
| sw_init | input | 1 | One-cycle software load of init_value |
| rd_strobe | input | 1 | Position registers read this cycle |
| init_value | input | 32 | Value loaded on initialization |
| upper_lim | input | 32 | Upper modulo limit |
| lower_lim | input | 32 | Lower modulo limit |
| compare_val | input | 32 | Compare value |
| flag_clr | input | 6 | Write-one-to-clear for flags |
| irq_en | input | 6 | Interrupt enable per flag |
| position | output | 32 | Position counter |
| pos_diff | output | 16 | Position difference since last read |
| revolution | output | 16 | Revolution counter |
| dir_up | output | 1 | Direction of last applied count |
| match_pulse | output | 1 | Compare or read pulse |
| flags | output | 6 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
The position register shows every state error. A misdecoded step, a wrong priority between load and count, or a bad wrap limit changes position at the third edge after the phase edge that caused it, and the error stays until the next load. A direction error shows on dir_up in that same cycle. It then shows on revolution at the next index edge, so the bench must place index edges after a direction change. Flag and match faults appear one edge after the event. Because the flags are sticky, a missed set is still visible until a clear.

// File: rtl/qdec_position.sv
module qdec_position #(
  parameter int POS_W  = 32,
  parameter int REV_W  = 16,
  parameter int DIFF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              index_in,
  input  logic              home_in,
  input  logic              trigger_in,
  input  logic              cfg_count_mode,
  input  logic              cfg_reverse,
  input  logic              cfg_modulo_en,
  input  logic              cfg_rev_src,
  input  logic              cfg_index_init_en,
  input  logic              cfg_index_fall,
  input  logic              cfg_home_init_en,
  input  logic              cfg_home_fall,
  input  logic              cfg_trig_clear_en,
  input  logic              cfg_match_on_read,
  input  logic              sw_init,
  input  logic              rd_strobe,
  input  logic [POS_W-1:0]  init_value,
  input  logic [POS_W-1:0]  upper_lim,
  input  logic [POS_W-1:0]  lower_lim,
  input  logic [POS_W-1:0]  compare_val,
  input  logic [5:0]        flag_clr,
  input  logic [5:0]        irq_en,
  output logic [POS_W-1:0]  position,
  output logic [DIFF_W-1:0] pos_diff,
  output logic [REV_W-1:0]  revolution,
  output logic              dir_up,
  output logic              match_pulse,
  output logic [5:0]        flags,
  output logic              irq
);

  localparam int NIN = 5;

  logic [NIN-1:0] sync1, sync2, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= {trigger_in, home_in, index_in, phase_b, phase_a};
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  logic chg_a, chg_b, cnt_en, cnt_up, sim_evt;
  logic idx_evt, home_evt, trig_clr, load_init, apply_cnt;
  logic roll_over, roll_under, pos_wr, cmp_hit;
  logic [POS_W-1:0]  top_lim, bot_lim, pos_nxt;
  logic [REV_W-1:0]  rev_nxt;
  logic [DIFF_W-1:0] diff_nxt;

  assign chg_a   = sync2[0] ^ last[0];
  assign chg_b   = sync2[1] ^ last[1];
  assign cnt_en  = cfg_count_mode ? (sync2[0] & ~last[0]) : (chg_a ^ chg_b);
  assign cnt_up  = cfg_count_mode ? ~(sync2[1] ^ cfg_reverse)
                                  : (sync2[0] ^ last[1] ^ cfg_reverse);
  assign sim_evt = ~cfg_count_mode & chg_a & chg_b;

  assign idx_evt  = cfg_index_fall ? (last[2] & ~sync2[2]) : (~last[2] & sync2[2]);
  assign home_evt = cfg_home_fall  ? (last[3] & ~sync2[3]) : (~last[3] & sync2[3]);
  assign trig_clr = cfg_trig_clear_en & ~last[4] & sync2[4];

  assign load_init = sw_init | (cfg_index_init_en & idx_evt) | (cfg_home_init_en & home_evt);
  assign apply_cnt = cnt_en & ~trig_clr & ~load_init;

  assign top_lim    = cfg_modulo_en ? upper_lim : '1;
  assign bot_lim    = cfg_modulo_en ? lower_lim : '0;
  assign roll_over  = apply_cnt &  cnt_up & (position == top_lim);
  assign roll_under = apply_cnt & ~cnt_up & (position == bot_lim);

  always_comb begin
    pos_nxt = position;
    pos_wr  = 1'b0;
    if (trig_clr) begin
      pos_nxt = '0;
      pos_wr  = 1'b1;
    end else if (load_init) begin
      pos_nxt = init_value;
      pos_wr  = 1'b1;
    end else if (apply_cnt) begin
      pos_wr = 1'b1;
      if (roll_over)       pos_nxt = bot_lim;
      else if (roll_under) pos_nxt = top_lim;
      else if (cnt_up)     pos_nxt = position + 1'b1;
      else                 pos_nxt = position - 1'b1;
    end
  end

  always_comb begin
    rev_nxt = revolution;
    if (trig_clr)
      rev_nxt = '0;
    else if (!cfg_rev_src && idx_evt)
      rev_nxt = dir_up ? revolution + 1'b1 : revolution - 1'b1;
    else if (cfg_rev_src && roll_over)
      rev_nxt = revolution + 1'b1;
    else if (cfg_rev_src && roll_under)
      rev_nxt = revolution - 1'b1;
  end

  always_comb begin
    diff_nxt = pos_diff;
    if (trig_clr || rd_strobe) diff_nxt = '0;
    else if (apply_cnt)        diff_nxt = cnt_up ? pos_diff + 1'b1 : pos_diff - 1'b1;
  end

  assign cmp_hit = pos_wr & (pos_nxt == compare_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position    <= '0;
      pos_diff    <= '0;
      revolution  <= '0;
      dir_up      <= 1'b0;
      match_pulse <= 1'b0;
      flags       <= '0;
    end else begin
      position    <= pos_nxt;
      pos_diff    <= diff_nxt;
      revolution  <= rev_nxt;
      if (apply_cnt) dir_up <= cnt_up;
      match_pulse <= cfg_match_on_read ? rd_strobe : cmp_hit;
      flags       <= (flags & ~flag_clr)
                   | {sim_evt, home_evt, idx_evt, roll_under, roll_over, cmp_hit};
    end
  end

  assign irq = |(flags & irq_en);

endmodule

// File: rtl/qdec_position_chk.sv
module qdec_position_chk #(
  parameter int POS_W  = 32,
  parameter int REV_W  = 16,
  parameter int DIFF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_modulo_en,
  input logic              cfg_match_on_read,
  input logic              rd_strobe,
  input logic [POS_W-1:0]  init_value,
  input logic [POS_W-1:0]  upper_lim,
  input logic [POS_W-1:0]  lower_lim,
  input logic [5:0]        flag_clr,
  input logic [POS_W-1:0]  position,
  input logic [DIFF_W-1:0] pos_diff,
  input logic [REV_W-1:0]  revolution,
  input logic              dir_up,
  input logic              match_pulse,
  input logic [5:0]        flags,
  input logic              apply_cnt,
  input logic              cnt_up,
  input logic              trig_clr,
  input logic              load_init,
  input logic              sim_evt
);

  a_r5_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_cnt && cnt_up) |=> dir_up);

  a_r5_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_cnt && !cnt_up) |=> !dir_up);

  a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_modulo_en && apply_cnt && cnt_up && position == upper_lim)
      |=> (position == $past(lower_lim) && flags[1]));

  a_r8_init_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_init && !trig_clr) |=> position == $past(init_value));

  a_r9_trigger_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trig_clr |=> (position == '0 && revolution == '0 && pos_diff == '0));

  a_r10_both_change_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_evt && !trig_clr && !load_init) |=> ($stable(position) && flags[5]));

  a_r11_read_match: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_match_on_read && rd_strobe) |=> match_pulse);

  a_r12_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

endmodule

bind qdec_position qdec_position_chk #(.POS_W(POS_W), .REV_W(REV_W), .DIFF_W(DIFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_modulo_en(cfg_modulo_en),
  .cfg_match_on_read(cfg_match_on_read), .rd_strobe(rd_strobe),
  .init_value(init_value), .upper_lim(upper_lim), .lower_lim(lower_lim),
  .flag_clr(flag_clr), .position(position), .pos_diff(pos_diff),
  .revolution(revolution), .dir_up(dir_up), .match_pulse(match_pulse),
  .flags(flags), .apply_cnt(apply_cnt), .cnt_up(cnt_up), .trig_clr(trig_clr),
  .load_init(load_init), .sim_evt(sim_evt)
);

// File: tb/tb_qdec_position.sv
`timescale 1ns/1ps
module tb_qdec_position;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic phase_a = 0, phase_b = 0, index_in = 0, home_in = 0, trigger_in = 0;
  logic cfg_count_mode = 0, cfg_reverse = 0, cfg_modulo_en = 0, cfg_rev_src = 0;
  logic cfg_index_init_en = 0, cfg_index_fall = 0, cfg_home_init_en = 0, cfg_home_fall = 0;
  logic cfg_trig_clear_en = 0, cfg_match_on_read = 0, sw_init = 0, rd_strobe = 0;
  logic [31:0] init_value = 32'h100, upper_lim = 32'd8, lower_lim = 32'd5, compare_val = 32'd3;
  logic [5:0] flag_clr = '0, irq_en = '0;
  logic [31:0] position;
  logic [15:0] pos_diff, revolution;
  logic dir_up, match_pulse, irq;
  logic [5:0] flags;

  qdec_position dut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .home_in(home_in), .trigger_in(trigger_in),
    .cfg_count_mode(cfg_count_mode), .cfg_reverse(cfg_reverse),
    .cfg_modulo_en(cfg_modulo_en), .cfg_rev_src(cfg_rev_src),
    .cfg_index_init_en(cfg_index_init_en), .cfg_index_fall(cfg_index_fall),
    .cfg_home_init_en(cfg_home_init_en), .cfg_home_fall(cfg_home_fall),
    .cfg_trig_clear_en(cfg_trig_clear_en), .cfg_match_on_read(cfg_match_on_read),
    .sw_init(sw_init), .rd_strobe(rd_strobe), .init_value(init_value),
    .upper_lim(upper_lim), .lower_lim(lower_lim), .compare_val(compare_val),
    .flag_clr(flag_clr), .irq_en(irq_en), .position(position),
    .pos_diff(pos_diff), .revolution(revolution), .dir_up(dir_up),
    .match_pulse(match_pulse), .flags(flags), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [4:0]  hq[$];
  logic [31:0] m_pos = 0;
  logic [15:0] m_diff = 0, m_rev = 0;
  logic        m_dir = 0, m_match = 0;
  logic [5:0]  m_flags = 0;

  function automatic int gray_idx(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [4:0] nw, od;
    logic cnt, up, sim, ie, he, tc, ld, ro, ru, wr;
    logic [31:0] top, bot, np;
    int d;
    if (!rst_n) begin
      hq = '{5'd0, 5'd0, 5'd0, 5'd0};
      m_pos = 0; m_diff = 0; m_rev = 0; m_dir = 0; m_match = 0; m_flags = 0;
    end else begin
      hq.push_front({trigger_in, home_in, index_in, phase_b, phase_a});
      void'(hq.pop_back());
      nw = hq[2];
      od = hq[3];
      sim = 0;
      if (cfg_count_mode) begin
        cnt = !od[0] && nw[0];
        up  = (nw[1] == cfg_reverse);
      end else begin
        d = (gray_idx(nw[0], nw[1]) - gray_idx(od[0], od[1]) + 4) % 4;
        cnt = (d == 1) || (d == 3);
        up  = (d == 1) ^ cfg_reverse;
        sim = (d == 2);
      end
      ie = cfg_index_fall ? (od[2] && !nw[2]) : (!od[2] && nw[2]);
      he = cfg_home_fall  ? (od[3] && !nw[3]) : (!od[3] && nw[3]);
      tc = cfg_trig_clear_en && !od[4] && nw[4];
      ld = sw_init || (cfg_index_init_en && ie) || (cfg_home_init_en && he);
      top = cfg_modulo_en ? upper_lim : 32'hFFFF_FFFF;
      bot = cfg_modulo_en ? lower_lim : 32'h0;
      ro = 0; ru = 0; wr = 0; np = m_pos;
      if (tc) begin
        np = 0; wr = 1;
      end else if (ld) begin
        np = init_value; wr = 1;
      end else if (cnt) begin
        wr = 1;
        if (up && m_pos == top)       begin np = bot; ro = 1; end
        else if (!up && m_pos == bot) begin np = top; ru = 1; end
        else np = up ? m_pos + 1 : m_pos - 1;
      end
      if (tc) m_rev = 0;
      else if (!cfg_rev_src && ie) m_rev = m_dir ? m_rev + 16'd1 : m_rev - 16'd1;
      else if (cfg_rev_src && ro) m_rev = m_rev + 16'd1;
      else if (cfg_rev_src && ru) m_rev = m_rev - 16'd1;
      if (tc || rd_strobe) m_diff = 0;
      else if (cnt && !ld) m_diff = up ? m_diff + 16'd1 : m_diff - 16'd1;
      if (cnt && !ld && !tc) m_dir = up;
      m_match = cfg_match_on_read ? rd_strobe : (wr && np == compare_val);
      m_flags = (m_flags & ~flag_clr) | {sim, he, ie, ru, ro, wr && np == compare_val};
      m_pos = np;
    end
  end

  always @(negedge clk) begin
    chk("R3 position", 64'(position), 64'(m_pos));
    chk("R7 revolution", 64'(revolution), 64'(m_rev));
    chk("R13 pos_diff", 64'(pos_diff), 64'(m_diff));
    chk("R5 dir_up", 64'(dir_up), 64'(m_dir));
    chk("R12 flags", 64'(flags), 64'(m_flags));
    chk("R11 match_pulse", 64'(match_pulse), 64'(m_match));
    chk("R12 irq", 64'(irq), 64'(|(m_flags & irq_en)));
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quad(input logic a, input logic b);
    phase_a = a; phase_b = b; cyc(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset position", 64'(position), 64'd0);
    chk("R1 reset outputs", 64'({revolution, pos_diff, dir_up, match_pulse, flags, irq}), 64'd0);

    // R3 quadrature up
    quad(1,0); quad(1,1); quad(0,1); quad(0,0); quad(1,0); quad(1,1);
    chk("R3 six up steps", 64'(position), 64'd6);
    // R2 latency: unchanged after two edges, updated at the third
    phase_a = 0; phase_b = 1;
    cyc(2);
    chk("R2 not yet counted", 64'(position), 64'd6);
    cyc(1);
    chk("R2 counted at third edge", 64'(position), 64'd7);
    cyc(2);
    quad(1,1); quad(1,0);
    cfg_reverse = 1; quad(1,1); cfg_reverse = 0;
    chk("R3 reverse counts down", 64'(position), 64'd4);
    chk("R5 last count down", 64'(dir_up), 64'd0);

    // R10 both phases change at once
    quad(0,0);
    chk("R10 no count", 64'(position), 64'd4);
    chk("R10 flag bit5", 64'(flags[5]), 64'd1);

    // R4 phase-count mode
    cfg_count_mode = 1;
    quad(1,0); quad(0,0); quad(1,0); quad(0,0);
    quad(0,1); quad(1,1); quad(0,1);
    cfg_reverse = 1; quad(1,1); quad(0,1);
    cfg_reverse = 0; quad(0,0);
    cfg_count_mode = 0; cyc(2);
    chk("R4 phase-count result", 64'(position), 64'd6);

    // R8 software init, R6/R7 modulo wrap and revolution from wraps
    init_value = 32'd5;
    sw_init = 1; cyc(1); sw_init = 0; cyc(1);
    chk("R8 software init", 64'(position), 64'd5);
    cfg_modulo_en = 1; cfg_rev_src = 1;
    quad(1,0); quad(1,1); quad(0,1); quad(0,0);
    chk("R6 wrap up to lower", 64'(position), 64'd5);
    chk("R6 wrap up flag", 64'(flags[1]), 64'd1);
    chk("R7 revolution from wrap", 64'(revolution), 64'd1);
    quad(0,1);
    chk("R6 wrap down to upper", 64'(position), 64'd8);
    chk("R7 revolution down", 64'(revolution), 64'd0);
    cfg_modulo_en = 0; cfg_rev_src = 0;

    // R7 index-driven revolution, direction down
    index_in = 1; cyc(4); index_in = 0; cyc(4);
    chk("R7 index step with dir down", 64'(revolution), 64'hFFFF);
    chk("R12 index flag", 64'(flags[3]), 64'd1);

    // R8 index init on falling edge only
    cfg_index_init_en = 1; cfg_index_fall = 1; init_value = 32'h1234;
    index_in = 1; cyc(4);
    chk("R8 rising index ignored", 64'(position), 64'd8);
    index_in = 0; cyc(4);
    chk("R8 falling index loads", 64'(position), 64'h1234);
    cfg_index_init_en = 0; cfg_index_fall = 0;

    // R8 home init on rising edge
    cfg_home_init_en = 1; init_value = 32'h40;
    home_in = 1; cyc(4); home_in = 0; cyc(4);
    chk("R8 home loads", 64'(position), 64'h40);
    chk("R12 home flag", 64'(flags[4]), 64'd1);
    cfg_home_init_en = 0;

    // R9 trigger clear
    cfg_trig_clear_en = 1;
    trigger_in = 1; cyc(4); trigger_in = 0; cyc(4);
    chk("R9 trigger clears", 64'({position, revolution, pos_diff}), 64'd0);
    cfg_trig_clear_en = 0;

    // R6 plain wrap below zero
    quad(1,1);
    chk("R6 wrap to all ones", 64'(position), 64'hFFFF_FFFF);
    chk("R13 diff after one down", 64'(pos_diff), 64'hFFFF);

    // R11 compare match pulse timing
    compare_val = 32'hFFFF_FFFE;
    phase_a = 1; phase_b = 0;
    cyc(3);
    chk("R11 compare match pulse", 64'(match_pulse), 64'd1);
    cyc(1);
    chk("R11 pulse one cycle", 64'(match_pulse), 64'd0);

    // R11 read mode, R13 read clears diff
    cfg_match_on_read = 1;
    rd_strobe = 1; cyc(1); rd_strobe = 0;
    chk("R11 read match", 64'(match_pulse), 64'd1);
    chk("R13 diff cleared by read", 64'(pos_diff), 64'd0);
    cyc(2);
    cfg_match_on_read = 0;

    // R12 interrupt and clear
    irq_en = 6'h3F; cyc(1);
    chk("R12 irq with flags", 64'(irq), 64'd1);
    flag_clr = 6'h3F; cyc(1); flag_clr = '0; cyc(1);
    chk("R12 flags cleared", 64'(flags), 64'd0);
    chk("R12 irq low", 64'(irq), 64'd0);
    cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule